// File: doc/BRIEF.md
# Overlapped Address Translation and Cache Lookup

This block resolves one memory request per cycle. It looks the request up in a small translation buffer and in a physically tagged, direct-mapped cache at the same time. The cache is indexed only by untranslated page-offset bits, so both arrays are read in the same cycle. The frame number from the translation buffer is then compared against the tag stored in the selected cache line. The request ends in exactly one of four outcomes: data is delivered from the cache, memory is accessed at the translated physical address, a full translation is requested, or an access-rights violation is flagged.

The translation buffer is loaded through a refill port by an external page-table walker. The cache lines are written through a separate line-fill port by the memory side. Each buffer entry holds a virtual page, a physical frame, access rights and referenced/dirty flags. The flags of the matching entry are shown on the outputs during a lookup.

Top module: `xlat_cache_lookup`

## Requirements
- R1: After reset every translation entry and every cache line is invalid, so any request reports a translation miss.
- R2: The virtual address splits into page number [31:12] and offset [11:0]. The cache line index is [11:2] and bits [1:0] select the byte. The physical address on `mem_paddr_o` is {frame, offset}.
- R3: The lookup is combinational in the request cycle. An entry hits when it is valid and its virtual page equals the request's page number. With no request, all outcome outputs and data outputs are zero.
- R4: A read that hits in the buffer, has read permission, and finds a valid line whose tag equals the translated frame raises `hit_o` with that line's data on `rdata_o`.
- R5: A permitted read that hits in the buffer but finds an invalid line, or a tag different from the frame, raises `mem_req_o` with the translated physical address.
- R6: A request whose page misses in the buffer raises only `xlat_miss_o`. Every request raises exactly one outcome.
- R7: The buffer holds 8 entries. A refill takes the lowest-numbered invalid entry. When all entries are valid, it takes the entry at a round-robin pointer that starts at entry 0 and advances by one per such replacement.
- R8: Any buffer hit sets the entry's referenced flag, and a permitted write hit sets its dirty flag. A refill clears both flags. The flags of the hitting entry appear on `entry_ref_o` and `entry_dirty_o` before that cycle's update.
- R9: The rights field has bit 1 = write allowed and bit 0 = read allowed. An access without the needed right raises `prot_fault_o` with no memory access, no delivered data, and no dirty update.
- R10: A permitted write that hits in the buffer always raises `mem_req_o` with the physical address and never `hit_o`.
- R11: A line fill writes the tag, the data and the valid bit of the line at the given index. The line is visible to lookups from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | Request is a write |
| req_vaddr_i | input | 32 | Virtual address |
| tlb_fill_i | input | 1 | Load one translation entry |
| tlb_fill_vpn_i | input | 20 | Virtual page of the new entry |
| tlb_fill_ppn_i | input | 20 | Physical frame of the new entry |
| tlb_fill_perm_i | input | 2 | Rights: bit 1 write, bit 0 read |
| line_fill_i | input | 1 | Write one cache line |
| line_fill_idx_i | input | 10 | Line index to write |
| line_fill_tag_i | input | 20 | Physical frame stored as tag |
| line_fill_data_i | input | 32 | Line data |
| hit_o | output | 1 | Data delivered from cache |
| rdata_o | output | 32 | Delivered data, zero otherwise |
| mem_req_o | output | 1 | Access memory at physical address |
| mem_paddr_o | output | 32 | Physical address, zero without mem_req_o |
| xlat_miss_o | output | 1 | Full translation needed |
| prot_fault_o | output | 1 | Access rights violated |
| entry_dirty_o | output | 1 | Dirty flag of hitting entry |
| entry_ref_o | output | 1 | Referenced flag of hitting entry |

## Verification
Reads are tried against an empty cache, against a matching line, at another byte of the same line, at a neighbouring index, and against a line holding a foreign tag. Together these separate the deliver path from the memory path and show that the tag compare uses the translated frame. Writes and reads are sent to read-only and write-only pages, which separates rights faults from permitted accesses. Later lookups expose the flag updates. The buffer is then filled past capacity, so victims chosen by the round-robin pointer turn into translation misses while the other entries keep hitting. A pseudo-random mix of reads, writes and line fills is compared against a behavioural model on every cycle.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
  // bit 1: write allowed, bit 0: read allowed
  typedef struct packed {
    logic wr;
    logic rd;
  } perm_t;
endpackage

// File: rtl/xlc_tlb.sv
module xlc_tlb
  import xlc_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ENTRIES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_en_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             lk_hit_o,
  output logic [PPN_W-1:0] lk_ppn_o,
  output perm_t            lk_perm_o,
  output logic             lk_dirty_o,
  output logic             lk_ref_o,
  input  logic             acc_i,
  input  logic             acc_wr_i,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  perm_t            fill_perm_i
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPN_W-1:0] vpn_q  [ENTRIES];
  logic [PPN_W-1:0] ppn_q  [ENTRIES];
  perm_t            perm_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, dirty_q, ref_q, match;
  logic [IW-1:0] hit_idx, free_idx, fill_idx, rr_q;
  logic          any_free;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (vpn_q[g] == lk_vpn_i);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) hit_idx = IW'(i);
  end

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_q[i]) begin
        free_idx = IW'(i);
        any_free = 1'b1;
      end
  end

  assign fill_idx   = any_free ? free_idx : rr_q;
  assign lk_hit_o   = lk_en_i && (|match);
  assign lk_ppn_o   = ppn_q[hit_idx];
  assign lk_perm_o  = perm_q[hit_idx];
  assign lk_dirty_o = dirty_q[hit_idx];
  assign lk_ref_o   = ref_q[hit_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      ref_q   <= '0;
      rr_q    <= '0;
    end else begin
      if (acc_i) begin
        ref_q[hit_idx] <= 1'b1;
        if (acc_wr_i) dirty_q[hit_idx] <= 1'b1;
      end
      if (fill_i) begin
        valid_q[fill_idx] <= 1'b1;
        dirty_q[fill_idx] <= 1'b0;
        ref_q[fill_idx]   <= 1'b0;
        if (!any_free) rr_q <= (rr_q == IW'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      vpn_q[fill_idx]  <= fill_vpn_i;
      ppn_q[fill_idx]  <= fill_ppn_i;
      perm_q[fill_idx] <= fill_perm_i;
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match)); // R3
  AST_REF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !(fill_i && fill_idx == hit_idx)) |=> ref_q[$past(hit_idx)]); // R8
  AST_DIRTY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && acc_wr_i && !(fill_i && fill_idx == hit_idx)) |=> dirty_q[$past(hit_idx)]); // R8
  AST_FILL_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> valid_q[$past(fill_idx)] && vpn_q[$past(fill_idx)] == $past(fill_vpn_i)); // R7
endmodule

// File: rtl/xlc_cache.sv
module xlc_cache #(
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              fill_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [DATA_W-1:0] fill_data_i
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     valid_q <= '0;
    else if (fill_i) valid_q[fill_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      tag_q[fill_idx_i]  <= fill_tag_i;
      data_q[fill_idx_i] <= fill_data_i;
    end
  end

  AST_LINE_WRITTEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> valid_q[$past(fill_idx_i)] && tag_q[$past(fill_idx_i)] == $past(fill_tag_i)); // R11
endmodule

// File: rtl/xlat_cache_lookup.sv
module xlat_cache_lookup
  import xlc_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PAGE_W      = 12,
  parameter int BYTE_W      = 2,
  parameter int TLB_ENTRIES = 8,
  parameter int DATA_W      = 32,
  localparam int VPN_W      = VA_W - PAGE_W,
  localparam int IDX_W      = PAGE_W - BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic              tlb_fill_i,
  input  logic [VPN_W-1:0]  tlb_fill_vpn_i,
  input  logic [VPN_W-1:0]  tlb_fill_ppn_i,
  input  logic [1:0]        tlb_fill_perm_i,
  input  logic              line_fill_i,
  input  logic [IDX_W-1:0]  line_fill_idx_i,
  input  logic [VPN_W-1:0]  line_fill_tag_i,
  input  logic [DATA_W-1:0] line_fill_data_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic [VA_W-1:0]   mem_paddr_o,
  output logic              xlat_miss_o,
  output logic              prot_fault_o,
  output logic              entry_dirty_o,
  output logic              entry_ref_o
);
  logic              tlb_hit, lk_dirty, lk_ref, c_valid, allowed, line_hit;
  logic [VPN_W-1:0]  ppn, c_tag;
  logic [DATA_W-1:0] c_data;
  perm_t             perm;

  xlc_tlb #(.VPN_W(VPN_W), .PPN_W(VPN_W), .ENTRIES(TLB_ENTRIES)) i_tlb (
    .clk_i, .rst_ni,
    .lk_en_i    (req_valid_i),
    .lk_vpn_i   (req_vaddr_i[VA_W-1:PAGE_W]),
    .lk_hit_o   (tlb_hit),
    .lk_ppn_o   (ppn),
    .lk_perm_o  (perm),
    .lk_dirty_o (lk_dirty),
    .lk_ref_o   (lk_ref),
    .acc_i      (tlb_hit),
    .acc_wr_i   (req_write_i && perm.wr),
    .fill_i     (tlb_fill_i),
    .fill_vpn_i (tlb_fill_vpn_i),
    .fill_ppn_i (tlb_fill_ppn_i),
    .fill_perm_i(perm_t'(tlb_fill_perm_i))
  );

  // index from offset bits only: array read overlaps translation
  xlc_cache #(.IDX_W(IDX_W), .TAG_W(VPN_W), .DATA_W(DATA_W)) i_cache (
    .clk_i, .rst_ni,
    .rd_idx_i   (req_vaddr_i[PAGE_W-1:BYTE_W]),
    .rd_valid_o (c_valid),
    .rd_tag_o   (c_tag),
    .rd_data_o  (c_data),
    .fill_i     (line_fill_i),
    .fill_idx_i (line_fill_idx_i),
    .fill_tag_i (line_fill_tag_i),
    .fill_data_i(line_fill_data_i)
  );

  assign allowed       = req_write_i ? perm.wr : perm.rd;
  assign line_hit      = c_valid && (c_tag == ppn);
  assign hit_o         = tlb_hit && allowed && !req_write_i && line_hit;
  assign mem_req_o     = tlb_hit && allowed && (req_write_i || !line_hit);
  assign prot_fault_o  = tlb_hit && !allowed;
  assign xlat_miss_o   = req_valid_i && !tlb_hit;
  assign rdata_o       = hit_o ? c_data : '0;
  assign mem_paddr_o   = mem_req_o ? {ppn, req_vaddr_i[PAGE_W-1:0]} : '0;
  assign entry_dirty_o = tlb_hit && lk_dirty;
  assign entry_ref_o   = tlb_hit && lk_ref;

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> $countones({hit_o, mem_req_o, xlat_miss_o, prot_fault_o}) == 1); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !(hit_o || mem_req_o || xlat_miss_o || prot_fault_o)); // R3
  AST_PADDR_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_paddr_o[PAGE_W-1:0] == req_vaddr_i[PAGE_W-1:0]); // R2
  AST_WRITE_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i) |-> !hit_o); // R10
endmodule

// File: tb/test_xlat_cache_lookup.sv
`timescale 1ns/1ps
module test_xlat_cache_lookup;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [31:0] req_vaddr = 0;
  logic        tfill = 0;
  logic [19:0] tvpn = 0, tppn = 0;
  logic [1:0]  tperm = 0;
  logic        lfill = 0;
  logic [9:0]  lidx = 0;
  logic [19:0] ltag = 0;
  logic [31:0] ldata = 0;
  logic        hit, mem_req, miss, fault, edirty, eref;
  logic [31:0] rdata, paddr;

  xlat_cache_lookup i_xlat_cache_lookup (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_vaddr_i(req_vaddr),
    .tlb_fill_i(tfill), .tlb_fill_vpn_i(tvpn), .tlb_fill_ppn_i(tppn), .tlb_fill_perm_i(tperm),
    .line_fill_i(lfill), .line_fill_idx_i(lidx), .line_fill_tag_i(ltag), .line_fill_data_i(ldata),
    .hit_o(hit), .rdata_o(rdata), .mem_req_o(mem_req), .mem_paddr_o(paddr),
    .xlat_miss_o(miss), .prot_fault_o(fault), .entry_dirty_o(edirty), .entry_ref_o(eref)
  );

  int n_checks = 0, n_fails = 0;
  bit done = 0;

  // behavioural model
  int m_vpn[8], m_ppn[8], m_perm[8];
  bit m_val[8], m_dirty[8], m_ref[8];
  int m_rr = 0;
  int c_tag[int], c_data[int];

  task automatic cyc(string req);
    logic [101:0] act, exp;
    int  j = -1, idx;
    bit  ok, lh;
    logic [31:0] ev = 0, ep = 0;
    bit eh = 0, em = 0, ex = 0, ef = 0, ed = 0, er = 0;
    @(negedge clk);
    if (req_valid) begin
      for (int k = 0; k < 8; k++)
        if (m_val[k] && m_vpn[k] == int'(req_vaddr[31:12])) j = k;
      if (j < 0) ex = 1;
      else begin
        idx = int'(req_vaddr[11:2]);
        ok  = req_write ? m_perm[j][1] : m_perm[j][0];
        lh  = c_tag.exists(idx) && c_tag[idx] == m_ppn[j];
        ed  = m_dirty[j];
        er  = m_ref[j];
        if (!ok) ef = 1;
        else if (!req_write && lh) begin eh = 1; ev = c_data[idx]; end
        else begin em = 1; ep = {m_ppn[j][19:0], req_vaddr[11:0]}; end
      end
    end
    act = {hit, rdata, mem_req, paddr, miss, fault, edirty, eref};
    exp = {eh, ev, em, ep, ex, ef, ed, er};
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s va=%h act=%h exp=%h", req, req_vaddr, act, exp);
    end
    if (j >= 0) begin
      m_ref[j] = 1;
      if (req_write && m_perm[j][1]) m_dirty[j] = 1;
    end
    if (tfill) begin
      int s = -1;
      for (int k = 7; k >= 0; k--) if (!m_val[k]) s = k;
      if (s < 0) begin s = m_rr; m_rr = (m_rr + 1) % 8; end
      m_val[s] = 1; m_vpn[s] = int'(tvpn); m_ppn[s] = int'(tppn);
      m_perm[s] = int'(tperm); m_dirty[s] = 0; m_ref[s] = 0;
    end
    if (lfill) begin
      c_tag[int'(lidx)] = int'(ltag);
      c_data[int'(lidx)] = int'(ldata);
    end
    @(posedge clk); #1;
    req_valid = 0; req_write = 0; tfill = 0; lfill = 0;
  endtask

  task automatic rd(logic [31:0] va, string req);
    req_valid = 1; req_write = 0; req_vaddr = va; cyc(req);
  endtask
  task automatic wr(logic [31:0] va, string req);
    req_valid = 1; req_write = 1; req_vaddr = va; cyc(req);
  endtask
  task automatic tf(logic [19:0] v, logic [19:0] p, logic [1:0] pm, string req);
    tfill = 1; tvpn = v; tppn = p; tperm = pm; cyc(req);
  endtask
  task automatic lf(logic [19:0] t, logic [9:0] i, logic [31:0] d, string req);
    lfill = 1; ltag = t; lidx = i; ldata = d; cyc(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r = 32'h1234_5678;
    logic [19:0] vl [8];
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cyc("R3 idle");
    rd(32'h1234_5678, "R1 empty after reset");
    rd(32'h0000_0000, "R6 miss");
    tf(20'h12345, 20'hABCDE, 2'b11, "R7 fill e0");
    tf(20'h00010, 20'h00077, 2'b01, "R7 fill e1");
    tf(20'h00020, 20'h00088, 2'b10, "R7 fill e2");
    rd(32'h1234_5678, "R5 cold line, R2 paddr");
    lf(20'hABCDE, 10'h19E, 32'hCAFE_F00D, "R11 line fill");
    rd(32'h1234_5678, "R4 deliver");
    rd(32'h1234_567B, "R4 same line other byte R2");
    rd(32'h1234_567C, "R5 neighbour index");
    lf(20'h11111, 10'h19E, 32'h0BAD_0BAD, "R11 foreign tag");
    rd(32'h1234_5678, "R5 tag mismatch");
    lf(20'hABCDE, 10'h19E, 32'h5A5A_A5A5, "R11 restore");
    wr(32'h1234_5678, "R10 write goes to memory");
    rd(32'h1234_5678, "R8 dirty and ref visible");
    wr(32'h0001_0040, "R9 write to read-only");
    rd(32'h0001_0040, "R9 no dirty after fault");
    rd(32'h0002_0040, "R9 read to write-only");
    wr(32'h0002_0044, "R10 write-only page");
    for (int k = 0; k < 5; k++)
      tf(20'h00100 + 20'(k), 20'h00300 + 20'(k), 2'b11, "R7 fill to capacity");
    tf(20'h00200, 20'h00400, 2'b11, "R7 round-robin victim e0");
    rd(32'h1234_5678, "R7 evicted page misses");
    rd(32'h0002_0000, "R7 survivor hits");
    tf(20'h00201, 20'h00401, 2'b11, "R7 round-robin victim e1");
    rd(32'h0001_0000, "R7 second victim misses");
    rd(32'h0020_1010, "R7 new entry hits");
    vl = '{20'h00200, 20'h00201, 20'h00020, 20'h00100,
           20'h00101, 20'h00102, 20'h00103, 20'h12345};
    for (int n = 0; n < 400; n++) begin
      r = r * 32'd1103515245 + 32'd12345;
      case (r[31:30])
        2'd0: lf(20'h00300 + 20'(r[18:16] % 4), {5'd0, r[7:3]}, r, "R11 random fill");
        2'd1: wr({vl[r[22:20]], 7'd0, r[4:0]}, "R10 random write");
        default: rd({vl[r[22:20]], 7'd0, r[4:0]}, "R4 R5 R6 random read");
      endcase
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule